// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits next to a processor core and decides which of five interrupt sources the core should service next. One source is a non-maskable request that is captured on its rising edge and always wins. Three are vectored maskable levels, ranked from the highest to the lowest: an edge-captured level, and two level-sensitive levels. The fifth is a general, non-vectored request that the core answers with an acknowledge strobe. A mask register and a global enable gate the maskable sources. A small write port loads both.

The block reports the winner as a pending flag, a 16-bit restart address and a flag that says whether the winner carries its own address. When the core raises `take` while a request is pending, the block accepts that winner. It then clears the winner's capture latch where one exists and drops the global enable. If the winner is the general request, it pulses the acknowledge on the following cycle. Saving the program counter and stack handling are left to the core.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `irq_pending` and `gen_ack` are 0, the global enable is 0 and all three mask bits are 1 (masked). A maskable or general request raised with no configuration write is therefore not reported.
- R2: A rising edge on `nmi_in` is captured. From the next cycle `irq_pending` is 1 with `irq_vector` 16'h0024 and `irq_vectored` 1, even while the global enable is 0. Holding `nmi_in` high after the request is accepted does not raise it again.
- R3: A captured non-maskable request outranks every other source.
- R4: Among the enabled, unmasked sources the order is `lvl_hi` (vector 16'h003C), `lvl_mid` (16'h0034), `lvl_lo` (16'h002C), then `gen_req`. When `gen_req` wins, `irq_vector` is 16'h0000 and `irq_vectored` is 0.
- R5: `cfg_mask[2]`, `cfg_mask[1]` and `cfg_mask[0]` mask `lvl_hi`, `lvl_mid` and `lvl_lo`, with 1 meaning masked. A maskable source is reported only when the global enable is 1 and its mask bit is 0. `gen_req` is gated by the global enable alone.
- R6: A rising edge on `lvl_hi` is captured whether or not the source is masked. The capture stays set after the input falls, until it is accepted or `clr_hi` is pulsed. A new edge in the same cycle as a clear keeps it set.
- R7: `lvl_mid` and `lvl_lo` are level sensitive and are not captured: once the input falls, the source is no longer reported.
- R8: Accepting a request means `take` is 1 while `irq_pending` is 1. Acceptance clears the global enable from the next cycle and clears the winner's capture. `take` with nothing pending changes nothing.
- R9: `gen_ack` is a one-cycle pulse in the cycle after `gen_req` is accepted, and is 0 at all other times.
- R10: `cfg_we` loads `cfg_mask` and `cfg_ie` at the clock edge. An acceptance in the same cycle forces the global enable to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge captured |
| lvl_hi | input | 1 | Highest maskable request, rising-edge captured |
| lvl_mid | input | 1 | Middle maskable request, level sensitive |
| lvl_lo | input | 1 | Lowest vectored maskable request, level sensitive |
| gen_req | input | 1 | General non-vectored request, level sensitive |
| cfg_we | input | 1 | Write strobe for mask and enable |
| cfg_mask | input | 3 | New mask bits: [2] hi, [1] mid, [0] lo; 1 = masked |
| cfg_ie | input | 1 | New global enable |
| take | input | 1 | Core accepts the reported winner |
| clr_hi | input | 1 | Discards a captured `lvl_hi` edge |
| irq_pending | output | 1 | A source is ready for service |
| irq_vector | output | 16 | Restart address of the winner, 0 for the general request |
| irq_vectored | output | 1 | Winner carries its own restart address |
| gen_ack | output | 1 | Acknowledge pulse for an accepted general request |

## Verification
The bench aims at overlaps. A non-maskable edge arriving with every maskable level active must still report 0024; a design that ranked it with the maskable group would show 003C. A `lvl_hi` pulse that comes and goes while masked must surface once it is unmasked; a level-sensitive implementation would lose it. The bench holds `nmi_in` high after service to catch a design that retriggers on level. It also issues `take` together with a configuration write that sets the enable, where a design that lets the write win would re-admit a maskable source at once. Random traffic on all inputs, together with accepts and clears, is compared cycle by cycle against a model built in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W    = 16;
  localparam int NUM_MASK = 3;
  localparam int NUM_EDGE = 2;  // index 0: non-maskable, index 1: highest maskable

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_HI   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_LO   = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;

  function automatic logic [VEC_W-1:0] src_vector(irq_src_e s);
    case (s)
      SRC_NMI: return 16'h0024;
      SRC_HI:  return 16'h003C;
      SRC_MID: return 16'h0034;
      SRC_LO:  return 16'h002C;
      default: return '0;
    endcase
  endfunction

  function automatic logic src_has_vector(irq_src_e s);
    return (s != SRC_NONE) && (s != SRC_GEN);
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise_w;

  assign rise_w = din & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= din;
      if (rise_w)   pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NUM_MASK = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NUM_MASK-1:0] cfg_mask,
  input  logic                cfg_ie,
  input  logic                accept,
  output logic [NUM_MASK-1:0] mask_q,
  output logic                ie_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (cfg_we) mask_q <= cfg_mask;
      if (accept)      ie_q <= 1'b0;
      else if (cfg_we) ie_q <= cfg_ie;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
#(
  parameter int NUM_MASK = 3
) (
  input  logic                nmi_pend,
  input  logic                hi_pend,
  input  logic                mid_lvl,
  input  logic                lo_lvl,
  input  logic                gen_lvl,
  input  logic [NUM_MASK-1:0] mask_q,
  input  logic                ie_q,
  output irq_src_e            win_src
);
  localparam int NUM_REQ = NUM_MASK + 2;

  logic [NUM_MASK-1:0] mreq;
  logic [NUM_REQ-1:0]  elig;

  assign mreq = {hi_pend, mid_lvl, lo_lvl};

  // elig[NUM_REQ-1] is the top rank, elig[0] the general request
  assign elig[NUM_REQ-1] = nmi_pend;
  assign elig[0]         = gen_lvl & ie_q;

  genvar g;
  generate
    for (g = 0; g < NUM_MASK; g++) begin : g_mask
      assign elig[g+1] = mreq[g] & ie_q & ~mask_q[g];
    end
  endgenerate

  function automatic irq_src_e pick(logic [NUM_REQ-1:0] e);
    irq_src_e s;
    s = SRC_NONE;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (e[i]) begin
        case (i)
          0:       s = SRC_GEN;
          1:       s = SRC_LO;
          2:       s = SRC_MID;
          3:       s = SRC_HI;
          default: s = SRC_NMI;
        endcase
      end
    end
    return s;
  endfunction

  assign win_src = pick(elig);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nmi_in,
  input  logic                lvl_hi,
  input  logic                lvl_mid,
  input  logic                lvl_lo,
  input  logic                gen_req,
  input  logic                cfg_we,
  input  logic [NUM_MASK-1:0] cfg_mask,
  input  logic                cfg_ie,
  input  logic                take,
  input  logic                clr_hi,
  output logic                irq_pending,
  output logic [VEC_W-1:0]    irq_vector,
  output logic                irq_vectored,
  output logic                gen_ack
);
  logic [NUM_EDGE-1:0] edge_in;
  logic [NUM_EDGE-1:0] edge_clr;
  logic [NUM_EDGE-1:0] edge_pend;
  logic                nmi_pend;
  logic                hi_pend;
  logic                ie_q;
  logic [NUM_MASK-1:0] mask_q;
  logic                accept;
  irq_src_e            win_src;

  assign edge_in  = {lvl_hi, nmi_in};
  assign nmi_pend = edge_pend[0];
  assign hi_pend  = edge_pend[1];
  assign accept   = take & irq_pending;
  assign edge_clr = {clr_hi | (accept & (win_src == SRC_HI)),
                     accept & (win_src == SRC_NMI)};

  genvar g;
  generate
    for (g = 0; g < NUM_EDGE; g++) begin : g_edge
      irq_edge_latch u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (edge_in[g]),
        .clr  (edge_clr[g]),
        .pend (edge_pend[g])
      );
    end
  endgenerate

  irq_ctrl_regs #(.NUM_MASK(NUM_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_mask(cfg_mask),
    .cfg_ie  (cfg_ie),
    .accept  (accept),
    .mask_q  (mask_q),
    .ie_q    (ie_q)
  );

  irq_prio_pick #(.NUM_MASK(NUM_MASK)) u_pick (
    .nmi_pend(nmi_pend),
    .hi_pend (hi_pend),
    .mid_lvl (lvl_mid),
    .lo_lvl  (lvl_lo),
    .gen_lvl (gen_req),
    .mask_q  (mask_q),
    .ie_q    (ie_q),
    .win_src (win_src)
  );

  assign irq_pending  = (win_src != SRC_NONE);
  assign irq_vector   = src_vector(win_src);
  assign irq_vectored = src_has_vector(win_src);

  always_ff @(posedge clk) begin
    if (!rst_n) gen_ack <= 1'b0;
    else        gen_ack <= accept & (win_src == SRC_GEN);
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             clr_hi,
  input logic             irq_pending,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_vectored,
  input logic             gen_ack,
  input logic             nmi_pend,
  input logic             hi_pend,
  input logic             ie_q
);
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_pending && irq_vector == 16'h0024)); // R3
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |=> !gen_ack); // R9
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |-> $past(take && irq_pending && !irq_vectored)); // R9
  AST_TAKE_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_pending) |=> !ie_q); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !nmi_pend) |-> !irq_pending); // R5
  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pend && !take && !clr_hi) |=> hi_pend); // R6
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (.*);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_in, lvl_hi, lvl_mid, lvl_lo, gen_req;
  logic        cfg_we, cfg_ie, take, clr_hi;
  logic [2:0]  cfg_mask;
  logic        irq_pending, irq_vectored, gen_ack;
  logic [15:0] irq_vector;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench-side view of the required behaviour
  logic       m_nmi_prev, m_nmi, m_hi_prev, m_hi, m_ie, m_ack;
  logic [2:0] m_mask;

  always #5 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .lvl_hi(lvl_hi),
    .lvl_mid(lvl_mid), .lvl_lo(lvl_lo), .gen_req(gen_req),
    .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_ie(cfg_ie),
    .take(take), .clr_hi(clr_hi), .irq_pending(irq_pending),
    .irq_vector(irq_vector), .irq_vectored(irq_vectored), .gen_ack(gen_ack)
  );

  // 0 none, 1 nmi, 2 hi, 3 mid, 4 lo, 5 general
  function automatic int exp_win();
    if (m_nmi) return 1;
    if (!m_ie) return 0;
    if (m_hi && !m_mask[2]) return 2;
    if (lvl_mid && !m_mask[1]) return 3;
    if (lvl_lo && !m_mask[0]) return 4;
    if (gen_req) return 5;
    return 0;
  endfunction

  function automatic logic [15:0] exp_vec(int w);
    case (w)
      1: return 16'h0024;
      2: return 16'h003C;
      3: return 16'h0034;
      4: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int w;
    logic tk;
    #1;
    w = exp_win();
    chk(tag, "pending", {15'd0, irq_pending}, {15'd0, w != 0});
    chk(tag, "vector", irq_vector, exp_vec(w));
    chk(tag, "vectored", {15'd0, irq_vectored}, {15'd0, (w != 0 && w != 5)});
    chk(tag, "gen_ack", {15'd0, gen_ack}, {15'd0, m_ack});
    @(posedge clk);
    tk = take && (w != 0);
    if (nmi_in && !m_nmi_prev) m_nmi = 1'b1;
    else if (tk && w == 1)     m_nmi = 1'b0;
    if (lvl_hi && !m_hi_prev)            m_hi = 1'b1;
    else if (clr_hi || (tk && w == 2))   m_hi = 1'b0;
    if (cfg_we) begin m_mask = cfg_mask; m_ie = cfg_ie; end
    if (tk) m_ie = 1'b0;
    m_ack = tk && (w == 5);
    m_nmi_prev = nmi_in;
    m_hi_prev = lvl_hi;
    @(negedge clk);
    take = 1'b0; cfg_we = 1'b0; clr_hi = 1'b0;
  endtask

  task automatic cfg(logic [2:0] m, logic ie, string tag);
    cfg_we = 1'b1; cfg_mask = m; cfg_ie = ie;
    cyc(tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    {nmi_in, lvl_hi, lvl_mid, lvl_lo, gen_req} = '0;
    {cfg_we, cfg_ie, take, clr_hi} = '0;
    cfg_mask = 3'b000;
    rst_n = 1'b0;
    m_nmi_prev = 0; m_nmi = 0; m_hi_prev = 0; m_hi = 0; m_ie = 0; m_ack = 0;
    m_mask = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state; requests ignored with no configuration
    cyc("R1");
    lvl_mid = 1; lvl_lo = 1; gen_req = 1;
    cyc("R1"); cyc("R1");
    lvl_mid = 0; lvl_lo = 0; gen_req = 0;
    cyc("R1");

    // R2: non-maskable edge while enable is off, then held high
    nmi_in = 1; cyc("R2"); cyc("R2");
    take = 1; cyc("R2");
    cyc("R2"); cyc("R2");
    nmi_in = 0; cyc("R2");

    // R5: mask gating
    lvl_lo = 1; cfg(3'b111, 1, "R5"); cyc("R5");
    cfg(3'b110, 1, "R5"); cyc("R5");
    cfg(3'b110, 0, "R5"); cyc("R5");
    lvl_lo = 0;

    // R4: full order, accept each and re-enable
    lvl_hi = 1; lvl_mid = 1; lvl_lo = 1; gen_req = 1;
    cfg(3'b000, 1, "R4"); cyc("R4");
    for (int k = 0; k < 4; k++) begin
      take = 1; cyc("R4");
      if (k == 0) lvl_hi = 0;
      if (k == 1) lvl_mid = 0;
      if (k == 2) lvl_lo = 0;
      cfg(3'b000, 1, "R4"); cyc("R4");
    end
    take = 1; cyc("R9"); cyc("R9"); cyc("R9");
    gen_req = 0;

    // R3: non-maskable beats all maskable sources
    lvl_hi = 1; lvl_mid = 1; lvl_lo = 1;
    cfg(3'b000, 1, "R3");
    nmi_in = 1; cyc("R3"); cyc("R3");
    take = 1; cyc("R3"); cyc("R3");
    nmi_in = 0; lvl_mid = 0; lvl_lo = 0; lvl_hi = 0;
    clr_hi = 1; cyc("R6");

    // R6: masked pulse captured, cleared, set-over-clear
    cfg(3'b111, 1, "R6");
    lvl_hi = 1; cyc("R6"); lvl_hi = 0; cyc("R6"); cyc("R6");
    cfg(3'b000, 1, "R6"); cyc("R6");
    clr_hi = 1; cyc("R6"); cyc("R6");
    lvl_hi = 1; clr_hi = 1; cyc("R6"); lvl_hi = 0; cyc("R6");
    take = 1; cyc("R6"); cyc("R6");

    // R7: level sources drop with their inputs
    cfg(3'b000, 1, "R7");
    lvl_mid = 1; cyc("R7"); lvl_mid = 0; cyc("R7");
    lvl_lo = 1; cyc("R7"); lvl_lo = 0; cyc("R7");

    // R8: take with nothing pending has no effect
    take = 1; cyc("R8"); lvl_lo = 1; cyc("R8"); lvl_lo = 0;

    // R10: accept in the same cycle as an enabling write
    gen_req = 1; cyc("R10");
    take = 1; cfg_we = 1; cfg_mask = 3'b000; cfg_ie = 1; cyc("R10");
    cyc("R10"); gen_req = 0; cyc("R10");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      nmi_in  = ($urandom_range(0, 15) == 0);
      lvl_hi  = ($urandom_range(0, 7) == 0);
      lvl_mid = $urandom_range(0, 1) != 0;
      lvl_lo  = $urandom_range(0, 1) != 0;
      gen_req = $urandom_range(0, 1) != 0;
      take    = ($urandom_range(0, 2) == 0);
      clr_hi  = ($urandom_range(0, 9) == 0);
      cfg_we  = ($urandom_range(0, 3) == 0);
      cfg_mask = 3'($urandom_range(0, 7));
      cfg_ie  = ($urandom_range(0, 3) != 0);
      cyc("RND");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule